// File: doc/BRIEF.md
# Serial Flash Page Program Engine

This block is the write path of a small NOR flash array behind a serial port. A host opens a program frame by pulsing `prog_start` with a start address while chip select is held low. It then shifts data bits in, most significant bit first. The bytes collect in a one-page staging buffer. Columns advance from the start address and wrap inside the page. When chip select returns high after a whole number of bytes, the engine enters a timed busy period and merges the staged bytes into the array. Programming can only clear bits, so each target byte becomes the old byte ANDed with the new one. A separate `erase_start` pulse sets a whole page back to all ones. While either operation runs, the `wip` status bit is high, so software can poll it instead of waiting for the worst-case time. The array read port stays usable throughout.

The controller has four states. ST_IDLE waits for a command. ST_LOAD collects bits while chip select is low. ST_PROG runs the timed program commit. ST_ERASE runs the timed page erase. The transitions are:
- idle-to-erase on `erase_start`, which takes priority.
- idle-to-load on `prog_start` with chip select low.
- load-to-program when chip select rises with at least one complete byte and no stray bits.
- load-to-idle (cancel) when chip select rises with a partial byte or no bytes.
- program-to-idle and erase-to-idle when the busy timer expires.

Top module: `flash_pp_engine`

## Requirements
- R1: After reset `wip` is 0 and every array byte reads 8'hFF.
- R2: A committed program leaves each written byte equal to its previous value ANDed with the last byte supplied for that column. Columns that were not supplied keep their value.
- R3: Data columns start at the low address bits (`cmd_addr[7:0]` by default) and wrap from the last column of the page to column 0 of the same page. When more than a page of bytes arrives, later bytes replace earlier ones in the buffer, and the byte count saturates at one page.
- R4: A program holds `wip` high for exactly T_OVH + N*T_BYTE cycles, where N is the saturated byte count. `wip` first reads high in the cycle after the clock edge that sees chip select high. One long frame is therefore cheaper than several short frames carrying the same bytes.
- R5: A program frame is accepted only from idle with `cs_n` low when `prog_start` is sampled. Busy starts only when `cs_n` rises after a whole number of bytes.
- R6: If chip select rises with a partial byte pending, or with zero bytes, the frame is cancelled: `wip` stays 0 and the array is unchanged.
- R7: While `wip` is high, `prog_start` and `erase_start` are ignored. Reads are still served.
- R8: `erase_start` sampled in idle sets every byte of the page selected by the upper address bits to 8'hFF. `wip` stays high for max(T_ERASE, PAGE_BYTES) cycles. If both start pulses arrive together, erase wins.
- R9: Serial data is assembled most significant bit first, and the read port returns `mem[rd_addr]` one cycle after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select; a rising edge ends a program frame |
| prog_start | input | 1 | Opens a program frame at `cmd_addr` |
| erase_start | input | 1 | Starts a page erase of the page in `cmd_addr` |
| cmd_addr | input | ADDR_W | Byte address: page in the upper bits, column in the lower bits |
| bit_vld | input | 1 | Qualifies `bit_dat` |
| bit_dat | input | 1 | Serial data bit, MSB first |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Registered array read data |
| wip | output | 1 | Write-in-progress status |

## Verification
Each data bit is driven on a falling clock edge and registered at the next rising edge. The bench drops chip select on a falling edge, and `wip` is sampled one falling edge later, which is the first cycle it can be high. The bench then counts the falling edges at which `wip` reads high and compares the count with T_OVH + N*T_BYTE, or with the erase length. For a cancelled frame the count must be zero. Array contents are checked only after `wip` has fallen. Each read address is applied on one falling edge and the data is compared on the next, matching the one-register read latency. During a busy period, the ignored start pulses and a mid-busy read are timed by counting falling edges from the start of busy.

// File: rtl/flash_pp_pkg.sv
package flash_pp_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_PROG  = 2'd2,
        ST_ERASE = 2'd3
    } pp_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_pp_deser.sv
module flash_pp_deser
    import flash_pp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  bit_en,
    input  logic  bit_dat,
    output logic  byte_vld,
    output byte_t byte_out,
    output logic  bits_pending
);

    logic [6:0] shift_q;
    logic [2:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (clear) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (bit_en) begin
            shift_q <= {shift_q[5:0], bit_dat};
            cnt_q   <= cnt_q + 3'd1;
        end
    end

    always_comb begin
        byte_vld     = bit_en && (cnt_q == 3'd7);
        byte_out     = {shift_q, bit_dat};
        bits_pending = (cnt_q != 3'd0);
    end

endmodule

// File: rtl/flash_pp_pagebuf.sv
module flash_pp_pagebuf
    import flash_pp_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    localparam int COL_W = $clog2(PAGE_BYTES),
    localparam int CNT_W = COL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             wr_en,
    input  byte_t            wr_data,
    input  logic [COL_W-1:0] rd_col,
    output byte_t            rd_data,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(PAGE_BYTES);

    byte_t            stage_q [PAGE_BYTES];
    logic [COL_W-1:0] ptr_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            stage_q[ptr_q] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else if (start) begin
            ptr_q <= start_col;
            cnt_q <= '0;
        end else if (wr_en) begin
            ptr_q <= ptr_q + 1'b1;
            if (cnt_q != FULL) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign rd_data = stage_q[rd_col];
    assign count   = cnt_q;

endmodule

// File: rtl/flash_pp_array.sv
module flash_pp_array
    import flash_pp_pkg::*;
#(
    parameter int NUM_BYTES = 1024,
    localparam int AW = $clog2(NUM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_and,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    input  logic [AW-1:0] rd_addr,
    output byte_t         rd_data
);

    byte_t mem_q [NUM_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                mem_q[i] <= 8'hFF;
            end
            rd_data <= 8'hFF;
        end else begin
            if (wr_en) begin
                mem_q[wr_addr] <= wr_and ? (mem_q[wr_addr] & wr_data) : wr_data;
            end
            rd_data <= mem_q[rd_addr];
        end
    end

endmodule

// File: rtl/flash_pp_ctrl.sv
module flash_pp_ctrl
    import flash_pp_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int NUM_PAGES  = 4,
    parameter int T_OVH      = 20,
    parameter int T_BYTE     = 2,
    parameter int T_ERASE    = 300,
    localparam int COL_W  = $clog2(PAGE_BYTES),
    localparam int PG_W   = $clog2(NUM_PAGES),
    localparam int ADDR_W = COL_W + PG_W,
    localparam int CNT_W  = COL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              prog_start,
    input  logic              erase_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              bits_pending,
    input  logic [CNT_W-1:0]  buf_count,
    output logic              load_active,
    output logic              prog_accept,
    output logic              wr_en,
    output logic              wr_and,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [COL_W-1:0]  rd_col,
    output logic              wip
);

    localparam int ERASE_LEN = int'(max_u(T_ERASE, PAGE_BYTES));
    localparam int PROG_MAX  = T_OVH + PAGE_BYTES * T_BYTE;
    localparam int MAXD      = int'(max_u(ERASE_LEN, PROG_MAX));
    localparam int TMR_W     = $clog2(MAXD + 1);
    localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);

    pp_state_e         state_q, state_d;
    logic [TMR_W-1:0]  timer_q;
    logic [CNT_W-1:0]  walk_q;
    logic [CNT_W-1:0]  n_q;
    logic [PG_W-1:0]   page_q;
    logic [COL_W-1:0]  col_q;
    logic              commit_ok;
    logic              timer_done;
    logic [TMR_W-1:0]  prog_len;

    assign commit_ok  = cs_n && !bits_pending && (buf_count != '0);
    assign timer_done = (timer_q == '0);
    assign prog_len   = TMR_W'(T_OVH) + TMR_W'(buf_count) * TMR_W'(T_BYTE) - TMR_W'(1);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (erase_start) begin
                    state_d = ST_ERASE;
                end else if (prog_start && !cs_n) begin
                    state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (cs_n) begin
                    state_d = commit_ok ? ST_PROG : ST_IDLE;
                end
            end
            ST_PROG: begin
                if (timer_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ERASE: begin
                if (timer_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // timer, walk index and latched address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
            walk_q  <= '0;
            n_q     <= '0;
            page_q  <= '0;
            col_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (erase_start) begin
                        page_q  <= cmd_addr[ADDR_W-1:COL_W];
                        walk_q  <= '0;
                        timer_q <= TMR_W'(ERASE_LEN - 1);
                    end else if (prog_start && !cs_n) begin
                        page_q <= cmd_addr[ADDR_W-1:COL_W];
                        col_q  <= cmd_addr[COL_W-1:0];
                    end
                end
                ST_LOAD: begin
                    if (commit_ok) begin
                        n_q     <= buf_count;
                        walk_q  <= '0;
                        timer_q <= prog_len;
                    end
                end
                ST_PROG, ST_ERASE: begin
                    if (!timer_done) begin
                        timer_q <= timer_q - 1'b1;
                    end
                    if (wr_en) begin
                        walk_q <= walk_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from the state register
    always_comb begin
        load_active = 1'b0;
        wip         = 1'b0;
        wr_en       = 1'b0;
        wr_and      = 1'b0;
        wr_addr     = {page_q, col_q + walk_q[COL_W-1:0]};
        rd_col      = col_q + walk_q[COL_W-1:0];
        prog_accept = (state_q == ST_IDLE) && !erase_start && prog_start && !cs_n;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: load_active = 1'b1;
            ST_PROG: begin
                wip    = 1'b1;
                wr_and = 1'b1;
                wr_en  = (walk_q < n_q);
            end
            ST_ERASE: begin
                wip     = 1'b1;
                wr_en   = (walk_q < PAGE_CNT);
                wr_addr = {page_q, walk_q[COL_W-1:0]};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flash_pp_engine.sv
module flash_pp_engine
    import flash_pp_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int NUM_PAGES  = 4,
    parameter int T_OVH      = 20,
    parameter int T_BYTE     = 2,
    parameter int T_ERASE    = 300,
    localparam int COL_W  = $clog2(PAGE_BYTES),
    localparam int PG_W   = $clog2(NUM_PAGES),
    localparam int ADDR_W = COL_W + PG_W,
    localparam int CNT_W  = COL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              prog_start,
    input  logic              erase_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              bit_vld,
    input  logic              bit_dat,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              wip
);

    logic             load_active;
    logic             prog_accept;
    logic             bits_pending;
    logic             byte_vld;
    byte_t            byte_val;
    logic [CNT_W-1:0] buf_count;
    logic [COL_W-1:0] stage_col;
    byte_t            stage_byte;
    logic             arr_wr_en;
    logic             arr_wr_and;
    logic [ADDR_W-1:0] arr_wr_addr;
    byte_t            arr_wr_data;

    flash_pp_ctrl #(
        .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES),
        .T_OVH(T_OVH), .T_BYTE(T_BYTE), .T_ERASE(T_ERASE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
        .prog_start(prog_start), .erase_start(erase_start), .cmd_addr(cmd_addr),
        .bits_pending(bits_pending), .buf_count(buf_count),
        .load_active(load_active), .prog_accept(prog_accept),
        .wr_en(arr_wr_en), .wr_and(arr_wr_and), .wr_addr(arr_wr_addr),
        .rd_col(stage_col), .wip(wip)
    );

    flash_pp_deser u_deser (
        .clk(clk), .rst_n(rst_n), .clear(prog_accept),
        .bit_en(bit_vld && load_active), .bit_dat(bit_dat),
        .byte_vld(byte_vld), .byte_out(byte_val), .bits_pending(bits_pending)
    );

    flash_pp_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .start(prog_accept),
        .start_col(cmd_addr[COL_W-1:0]),
        .wr_en(byte_vld), .wr_data(byte_val),
        .rd_col(stage_col), .rd_data(stage_byte), .count(buf_count)
    );

    assign arr_wr_data = arr_wr_and ? stage_byte : 8'hFF;

    flash_pp_array #(.NUM_BYTES(PAGE_BYTES * NUM_PAGES)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(arr_wr_en), .wr_and(arr_wr_and), .wr_addr(arr_wr_addr),
        .wr_data(arr_wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

endmodule

// File: rtl/flash_pp_checker.sv
module flash_pp_checker #(
    parameter int PAGE_BYTES = 256,
    localparam int CNT_W = $clog2(PAGE_BYTES) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             erase_start,
    input logic             wip,
    input logic             load_active,
    input logic             bits_pending,
    input logic             arr_wr_en,
    input logic [CNT_W-1:0] buf_count
);

    p_write_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> wip);

    p_count_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_count <= CNT_W'(PAGE_BYTES));

    p_hold_while_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_active && !cs_n) |=> !wip);

    p_busy_trigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> ($past(cs_n) || $past(erase_start)));

    p_cancel_partial_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_active && cs_n && bits_pending) |=> !wip);

    p_busy_blocks_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wip |=> !load_active);

endmodule

bind flash_pp_engine flash_pp_checker #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .erase_start(erase_start),
    .wip(wip), .load_active(load_active), .bits_pending(bits_pending),
    .arr_wr_en(arr_wr_en), .buf_count(buf_count)
);

// File: tb/sim_flash_pp_engine.sv
module sim_flash_pp_engine;

    localparam int PAGE = 256;
    localparam int NPG  = 4;
    localparam int NB   = PAGE * NPG;
    localparam int AW   = 10;
    localparam int OVH  = 20;
    localparam int TB   = 2;
    localparam int TER  = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          prog_start = 1'b0;
    logic          erase_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          bit_vld = 1'b0;
    logic          bit_dat = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          wip;

    int total = 0;
    int bad   = 0;
    logic [7:0] model [NB];
    logic [7:0] pdata [300];

    always #2 clk = ~clk;

    flash_pp_engine #(
        .PAGE_BYTES(PAGE), .NUM_PAGES(NPG), .T_OVH(OVH), .T_BYTE(TB), .T_ERASE(TER)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .prog_start(prog_start),
        .erase_start(erase_start), .cmd_addr(cmd_addr), .bit_vld(bit_vld),
        .bit_dat(bit_dat), .rd_addr(rd_addr), .rd_data(rd_data), .wip(wip)
    );

    function automatic int prog_time(input int len);
        return OVH + ((len > PAGE) ? PAGE : len) * TB;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic measure_busy(output int n);
        n = 0;
        while (wip === 1'b1 && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_page(input int pg, input string req);
        int errs = 0;
        rd_addr = AW'(pg * PAGE);
        @(negedge clk);
        for (int c = 0; c < PAGE; c++) begin
            rd_addr = AW'(pg * PAGE + ((c + 1) % PAGE));
            if (rd_data !== model[pg * PAGE + c]) begin
                errs++;
                if (errs == 1) check(1'b0, req, int'(rd_data), int'(model[pg * PAGE + c]));
            end
            @(negedge clk);
        end
        if (errs == 0) check(1'b1, req, 0, 0);
    endtask

    task automatic model_prog(input int addr, input int len);
        int pg = addr / PAGE;
        int st = addr % PAGE;
        logic [7:0] last [PAGE];
        bit         used [PAGE];
        for (int c = 0; c < PAGE; c++) used[c] = 1'b0;
        for (int i = 0; i < len; i++) begin
            last[(st + i) % PAGE] = pdata[i];
            used[(st + i) % PAGE] = 1'b1;
        end
        for (int c = 0; c < PAGE; c++)
            if (used[c]) model[pg * PAGE + c] = model[pg * PAGE + c] & last[c];
    endtask

    // drives a frame; leaves the bench one falling edge after cs_n rose
    task automatic send_frame(input int addr, input int len, input int extra);
        cs_n = 1'b0; prog_start = 1'b1; cmd_addr = AW'(addr);
        @(negedge clk);
        prog_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            for (int b = 7; b >= 0; b--) begin
                bit_vld = 1'b1; bit_dat = pdata[i][b];
                @(negedge clk);
            end
        end
        for (int b = 0; b < extra; b++) begin
            bit_vld = 1'b1; bit_dat = b[0];
            @(negedge clk);
        end
        bit_vld = 1'b0; cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_prog(input int addr, input int len, input int extra, input string req);
        int n;
        send_frame(addr, len, extra);
        measure_busy(n);
        if (extra == 0 && len > 0) begin
            check(n == prog_time(len), "R4", n, prog_time(len));
            model_prog(addr, len);
        end else begin
            check(n == 0, "R6", n, 0);
        end
        check_page(addr / PAGE, req);
    endtask

    task automatic run_erase(input int pg);
        int n;
        erase_start = 1'b1; cmd_addr = AW'(pg * PAGE + 17);
        @(negedge clk);
        erase_start = 1'b0;
        measure_busy(n);
        check(n == TER, "R8", n, TER);
        for (int c = 0; c < PAGE; c++) model[pg * PAGE + c] = 8'hFF;
        check_page(pg, "R8");
    endtask

    initial begin
        #(4 * 190000);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int r;
        r = $urandom(1234);
        for (int i = 0; i < NB; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(wip === 1'b0, "R1", int'(wip), 0);
        check_page(0, "R1");
        check_page(3, "R1");

        // R9: MSB-first byte assembly
        pdata[0] = 8'h80;
        run_prog(3 * PAGE, 1, 0, "R9");

        // R2: plain program, then AND onto the same bytes
        for (int i = 0; i < 5; i++) pdata[i] = 8'(8'hF0 | i);
        run_prog(10, 5, 0, "R2");
        for (int i = 0; i < 5; i++) pdata[i] = 8'h3C;
        run_prog(10, 5, 0, "R2");

        // R3: wrap at the page end, and overlong frame
        for (int i = 0; i < 20; i++) pdata[i] = 8'($urandom);
        run_prog(PAGE + 250, 20, 0, "R3");
        for (int i = 0; i < 260; i++) pdata[i] = 8'($urandom);
        run_prog(2 * PAGE + 5, 260, 0, "R3");

        // R4: one long frame beats two short frames
        check(prog_time(4) < 2 * prog_time(2), "R4", prog_time(4), 2 * prog_time(2));

        // R6: partial byte and empty frame cancel
        for (int i = 0; i < 3; i++) pdata[i] = 8'h00;
        run_prog(3 * PAGE + 40, 3, 5, "R6");
        run_prog(3 * PAGE + 40, 0, 0, "R6");

        // R5: prog_start with cs_n high is not accepted
        cs_n = 1'b1; prog_start = 1'b1; cmd_addr = AW'(3 * PAGE);
        @(negedge clk);
        prog_start = 1'b0; cs_n = 1'b0;
        for (int b = 0; b < 8; b++) begin
            bit_vld = 1'b1; bit_dat = 1'b0;
            @(negedge clk);
        end
        bit_vld = 1'b0; cs_n = 1'b1;
        @(negedge clk);
        check(wip === 1'b0, "R5", int'(wip), 0);
        check_page(3, "R5");

        // R8: erase page 0
        run_erase(0);

        // R7: requests ignored during busy, reads served
        pdata[0] = 8'h5A; pdata[1] = 8'hA5;
        send_frame(PAGE + 100, 2, 0);
        n = 0;
        while (wip === 1'b1 && n < 5000) begin
            if (n == 3) begin erase_start = 1'b1; cmd_addr = AW'(PAGE); end
            if (n == 4) begin erase_start = 1'b0; prog_start = 1'b1; cs_n = 1'b0; cmd_addr = AW'(0); end
            if (n == 5) prog_start = 1'b0;
            if (n == 6) cs_n = 1'b1;
            if (n == 8) rd_addr = AW'(3 * PAGE);
            if (n == 9) check(rd_data === model[3 * PAGE], "R7", int'(rd_data), int'(model[3 * PAGE]));
            n++;
            @(negedge clk);
        end
        check(n == prog_time(2), "R7", n, prog_time(2));
        model_prog(PAGE + 100, 2);
        repeat (3) begin
            check(wip === 1'b0, "R7", int'(wip), 0);
            @(negedge clk);
        end
        check_page(1, "R7");
        check_page(0, "R7");

        // randomized mix
        for (int it = 0; it < 12; it++) begin
            int kind = $urandom_range(0, 9);
            int pg   = $urandom_range(0, NPG - 1);
            int col  = $urandom_range(0, PAGE - 1);
            int len  = $urandom_range(1, 40);
            int ext  = 0;
            if (kind == 0) begin
                run_erase(pg);
            end else begin
                if (kind == 1) len = $urandom_range(240, 270);
                if (kind == 2) ext = $urandom_range(1, 7);
                for (int i = 0; i < len; i++) pdata[i] = 8'($urandom);
                run_prog(pg * PAGE + col, len, ext, (ext != 0) ? "R6" : "R2");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule